// File: doc/BRIEF.md
# Packed-Word Colour Palette Loader

This block holds a 256-entry colour lookup table. Each entry has a red, a green and a blue component of 8 bits. A processor loads the table through four 32-bit registers. It first writes a starting entry number. It then writes the colour data as a stream. An internal entry pointer and component pointer advance on their own, so software never addresses individual components.

The block has two loading modes.

- **Packed mode:** every 32-bit data write carries four component bytes, taken most significant byte first. One write can therefore complete an entry and start the next. The pointers carry the position from one write to the next.
- **Single-byte mode:** only the top byte of each data write is used, so each write loads exactly one component.

The display side reads the table through a separate index port. The colour appears one clock after the index is presented.

The component pointer is a three-state machine with states `COMP_RED`, `COMP_GREEN` and `COMP_BLUE`. It has three transitions:

- **step:** RED to GREEN, GREEN to BLUE, and BLUE to RED. The step from BLUE to RED also increments the entry pointer.
- **reload:** any state goes to RED when the address register is written.
- **hold:** the state stays the same when neither the address register nor the data register is written.

In packed mode the machine takes four steps within one clock.

Top module: `palette_loader`

## Requirements
- R1: A write to register select 0 (address) loads the entry pointer from `wr_data[7:0]`. Reading select 0 returns the entry pointer zero-extended to 32 bits.
- R2: Components of an entry are loaded in the order red, green, blue. After blue is loaded, the entry pointer increments by one.
- R3: In packed mode, a write to select 1 (data) loads four components, taken from `wr_data[31:24]`, `[23:16]`, `[15:8]` and `[7:0]` in that order. The sequence may cross into the next entry.
- R4: In single-byte mode, a data write loads one component from `wr_data[31:24]`. Bits [23:0] are ignored.
- R5: An address write returns the component pointer to red.
- R6: Components of an entry that have not yet been written keep their previous values. Each byte is stored as it arrives.
- R7: Bit 0 of select 2 (control) chooses the mode: 1 means packed and 0 means single-byte. A read of select 2 returns that bit, with bits [31:1] reading 0.
- R8: The entry pointer wraps from 255 to 0. This includes the case where the wrap happens in the middle of a packed word.
- R9: `pix_rgb` shows the entry selected by `pix_idx` one clock later, with red in [23:16], green in [15:8] and blue in [7:0]. If a processor write to that entry happens in the same cycle, the new value is shown from the following cycle.
- R10: Select 3 (overlay) is a plain 32-bit register that reads back what was written. Writing it has no effect on the pointers or the table.
- R11: After reset, the pointers are at entry 0 and red, the mode is single-byte, the overlay register is 0, and all table entries are 0.
- R12: Reading select 1 returns 0. Reads of any register do not change any state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write register select (0 address, 1 data, 2 control, 3 overlay) |
| wr_data | input | 32 | Write data |
| rd_sel | input | 2 | Read register select |
| rd_data | output | 32 | Read data, combinational from `rd_sel` |
| pix_idx | input | 8 | Display lookup index |
| pix_rgb | output | 24 | Display colour, registered |

## Verification
The properties assume that at most one register write arrives per cycle, and that `wr_en`, `wr_sel` and `wr_data` never carry unknown values while the block is out of reset. They also assume that the mode bit only changes through a control write. The bench meets these assumptions by driving every input from tasks on the falling clock edge. It holds `wr_en` low between writes. It switches the mode only through control writes placed between data bursts, including a switch in the middle of an entry.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int unsigned BUS_W  = 32;
    localparam int unsigned COMP_W = 8;
    localparam int unsigned NCOMP  = 3;
    localparam int unsigned LANES  = BUS_W / COMP_W;

    typedef enum logic [1:0] {
        COMP_RED   = 2'd0,
        COMP_GREEN = 2'd1,
        COMP_BLUE  = 2'd2
    } comp_e;

    typedef enum logic [1:0] {
        REG_ADDR = 2'd0,
        REG_DATA = 2'd1,
        REG_CTRL = 2'd2,
        REG_OVL  = 2'd3
    } reg_e;

    // Component state machine: step transition
    function automatic comp_e comp_step(comp_e c);
        comp_e n;
        unique case (c)
            COMP_RED:   n = COMP_GREEN;
            COMP_GREEN: n = COMP_BLUE;
            COMP_BLUE:  n = COMP_RED;
            default:    n = COMP_RED;
        endcase
        return n;
    endfunction
endpackage

// File: rtl/pal_regs.sv
module pal_regs
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [BUS_W-1:0] wr_data,
    input  logic [1:0]       rd_sel,
    input  logic [IDX_W-1:0] ptr_entry,
    output logic             packed_mode,
    output logic             addr_load,
    output logic             data_push,
    output logic [BUS_W-1:0] rd_data
);
    logic             ctrl_q;
    logic [BUS_W-1:0] ovl_q;
    reg_e             wsel;
    reg_e             rsel;

    assign wsel        = reg_e'(wr_sel);
    assign rsel        = reg_e'(rd_sel);
    assign addr_load   = wr_en && (wsel == REG_ADDR);
    assign data_push   = wr_en && (wsel == REG_DATA);
    assign packed_mode = ctrl_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= 1'b0;
            ovl_q  <= '0;
        end else if (wr_en) begin
            if (wsel == REG_CTRL) ctrl_q <= wr_data[0];
            if (wsel == REG_OVL)  ovl_q  <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        unique case (rsel)
            REG_ADDR: rd_data = {{(BUS_W-IDX_W){1'b0}}, ptr_entry};
            REG_DATA: rd_data = '0;
            REG_CTRL: rd_data = {{(BUS_W-1){1'b0}}, ctrl_q};
            REG_OVL:  rd_data = ovl_q;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/pal_seq.sv
module pal_seq
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          addr_load,
    input  logic                          data_push,
    input  logic                          packed_mode,
    input  logic [BUS_W-1:0]              wr_data,
    output logic [LANES-1:0]              lane_we,
    output logic [LANES-1:0][IDX_W-1:0]   lane_idx,
    output logic [LANES-1:0][1:0]         lane_comp,
    output logic [LANES-1:0][COMP_W-1:0]  lane_byte,
    output logic [IDX_W-1:0]              ptr_entry,
    output comp_e                         ptr_comp
);
    comp_e            comp_q, comp_d;
    logic [IDX_W-1:0] entry_q, entry_d;

    comp_e            pos_comp [LANES+1];
    logic [IDX_W-1:0] pos_idx  [LANES+1];

    assign pos_comp[0] = comp_q;
    assign pos_idx[0]  = entry_q;

    // Unrolled chain of step transitions, one per byte lane
    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign pos_comp[k+1] = comp_step(pos_comp[k]);
        assign pos_idx[k+1]  = (pos_comp[k] == COMP_BLUE) ? pos_idx[k] + 1'b1 : pos_idx[k];
        assign lane_we[k]    = data_push && (packed_mode || (k == 0));
        assign lane_idx[k]   = pos_idx[k];
        assign lane_comp[k]  = pos_comp[k];
        assign lane_byte[k]  = wr_data[BUS_W-1-k*COMP_W -: COMP_W];
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            comp_q  <= COMP_RED;
            entry_q <= '0;
        end else begin
            comp_q  <= comp_d;
            entry_q <= entry_d;
        end
    end

    // Transitions: reload, step (one or LANES times), hold
    always_comb begin
        comp_d  = comp_q;
        entry_d = entry_q;
        if (addr_load) begin
            comp_d  = COMP_RED;
            entry_d = wr_data[IDX_W-1:0];
        end else if (data_push) begin
            if (packed_mode) begin
                comp_d  = pos_comp[LANES];
                entry_d = pos_idx[LANES];
            end else begin
                comp_d  = pos_comp[1];
                entry_d = pos_idx[1];
            end
        end
    end

    assign ptr_entry = entry_q;
    assign ptr_comp  = comp_q;
endmodule

// File: rtl/pal_store.sv
module pal_store
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [LANES-1:0]              lane_we,
    input  logic [LANES-1:0][IDX_W-1:0]   lane_idx,
    input  logic [LANES-1:0][1:0]         lane_comp,
    input  logic [LANES-1:0][COMP_W-1:0]  lane_byte,
    input  logic [IDX_W-1:0]              pix_idx,
    output logic [NCOMP*COMP_W-1:0]       pix_rgb
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    logic [COMP_W-1:0] mem [ENTRIES][NCOMP];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                for (int c = 0; c < NCOMP; c++) begin
                    mem[e][c] <= '0;
                end
            end
        end else begin
            for (int k = 0; k < LANES; k++) begin
                if (lane_we[k]) mem[lane_idx[k]][lane_comp[k]] <= lane_byte[k];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pix_rgb <= '0;
        else        pix_rgb <= {mem[pix_idx][0], mem[pix_idx][1], mem[pix_idx][2]};
    end
endmodule

// File: rtl/palette_loader.sv
module palette_loader
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [1:0]                wr_sel,
    input  logic [BUS_W-1:0]          wr_data,
    input  logic [1:0]                rd_sel,
    output logic [BUS_W-1:0]          rd_data,
    input  logic [IDX_W-1:0]          pix_idx,
    output logic [NCOMP*COMP_W-1:0]   pix_rgb
);
    logic                         packed_mode;
    logic                         addr_load;
    logic                         data_push;
    logic [IDX_W-1:0]             ptr_entry;
    comp_e                        ptr_comp;
    logic [LANES-1:0]             lane_we;
    logic [LANES-1:0][IDX_W-1:0]  lane_idx;
    logic [LANES-1:0][1:0]        lane_comp;
    logic [LANES-1:0][COMP_W-1:0] lane_byte;

    pal_regs #(.IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .ptr_entry(ptr_entry),
        .packed_mode(packed_mode), .addr_load(addr_load),
        .data_push(data_push), .rd_data(rd_data)
    );

    pal_seq #(.IDX_W(IDX_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .addr_load(addr_load), .data_push(data_push),
        .packed_mode(packed_mode), .wr_data(wr_data), .lane_we(lane_we),
        .lane_idx(lane_idx), .lane_comp(lane_comp), .lane_byte(lane_byte),
        .ptr_entry(ptr_entry), .ptr_comp(ptr_comp)
    );

    pal_store #(.IDX_W(IDX_W)) u_store (
        .clk(clk), .rst_n(rst_n), .lane_we(lane_we), .lane_idx(lane_idx),
        .lane_comp(lane_comp), .lane_byte(lane_byte), .pix_idx(pix_idx),
        .pix_rgb(pix_rgb)
    );
endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk
    import pal_pkg::*;
#(
    parameter int unsigned IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       wr_sel,
    input logic [BUS_W-1:0] wr_data,
    input logic [1:0]       rd_sel,
    input logic [BUS_W-1:0] rd_data,
    input logic             packed_mode,
    input logic [IDX_W-1:0] ptr_entry,
    input logic [1:0]       ptr_comp
);
    // R1
    addr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ptr_entry == $past(wr_data[IDX_W-1:0]));

    // R5
    comp_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> ptr_comp == 2'd0);

    // R2
    blue_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && !packed_mode && ptr_comp == 2'd2)
        |=> (ptr_comp == 2'd0 && ptr_entry == IDX_W'($past(ptr_entry) + 1'b1)));

    // R2
    comp_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_comp != 2'd3);

    // R3
    packed_red_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && packed_mode && ptr_comp == 2'd0)
        |=> (ptr_comp == 2'd1 && ptr_entry == IDX_W'($past(ptr_entry) + 1'b1)));

    // R3
    packed_blue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd1 && packed_mode && ptr_comp == 2'd2)
        |=> (ptr_comp == 2'd0 && ptr_entry == IDX_W'($past(ptr_entry) + 2'd2)));

    // R12
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && (wr_sel == 2'd0 || wr_sel == 2'd1))
        |=> ($stable(ptr_entry) && $stable(ptr_comp)));

    // R7
    ctrl_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_sel == 2'd2) |-> (rd_data[BUS_W-1:1] == '0 && rd_data[0] == packed_mode));
endmodule

bind palette_loader pal_loader_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
    .packed_mode(packed_mode), .ptr_entry(ptr_entry), .ptr_comp(ptr_comp)
);

// File: tb/test_palette_loader.sv
module test_palette_loader;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [31:0] rd_data;
    logic [7:0]  pix_idx = '0;
    logic [23:0] pix_rgb;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    palette_loader i_palette_loader (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .pix_idx(pix_idx), .pix_rgb(pix_rgb)
    );

    always #10 clk = ~clk;

    // Behavioural reference model
    int          mdl [256][3];
    int          mptr = 0;
    int          mcomp = 0;
    bit          mpacked = 1'b0;
    logic [31:0] movl = '0;
    logic [23:0] exp_rgb = '0;
    int          bq [$];

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < 256; e++) for (int c = 0; c < 3; c++) mdl[e][c] = 0;
            mptr = 0; mcomp = 0; mpacked = 1'b0; movl = '0; exp_rgb = '0;
        end else begin
            exp_rgb = {mdl[pix_idx][0][7:0], mdl[pix_idx][1][7:0], mdl[pix_idx][2][7:0]};
            if (wr_en) begin
                case (wr_sel)
                    2'd0: begin mptr = int'(wr_data[7:0]); mcomp = 0; end
                    2'd1: begin
                        bq.delete();
                        if (mpacked) for (int k = 0; k < 4; k++) bq.push_back(int'(wr_data[31-8*k -: 8]));
                        else bq.push_back(int'(wr_data[31:24]));
                        while (bq.size() > 0) begin
                            mdl[mptr][mcomp] = bq.pop_front();
                            mcomp++;
                            if (mcomp == 3) begin mcomp = 0; mptr = (mptr + 1) % 256; end
                        end
                    end
                    2'd2: mpacked = wr_data[0];
                    default: movl = wr_data;
                endcase
            end
        end
    end

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] model_rd(logic [1:0] s);
        case (s)
            2'd0:    return 32'(mptr);
            2'd1:    return 32'd0;
            2'd2:    return {31'd0, mpacked};
            default: return movl;
        endcase
    endfunction

    // Compare against the model on every clock
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(pix_rgb == exp_rgb, "R9 per-cycle lookup", {8'd0, pix_rgb}, {8'd0, exp_rgb});
            chk(rd_data == model_rd(rd_sel), "R12 per-cycle readback", rd_data, model_rd(rd_sel));
        end
    end

    task automatic wr(logic [1:0] s, logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 32'hDEAD_BEEF;
    endtask

    task automatic look(logic [7:0] idx, logic [23:0] exp, string tag);
        @(negedge clk);
        pix_idx = idx;
        @(negedge clk);
        chk(pix_rgb == exp, tag, {8'd0, pix_rgb}, {8'd0, exp});
    endtask

    task automatic rdreg(logic [1:0] s, logic [31:0] exp, string tag);
        rd_sel = s;
        #1;
        chk(rd_data == exp, tag, rd_data, exp);
    endtask

    initial begin
        #(20 * 200000);
        if (!done) begin
            done = 1'b1;
            errors++;
            $display("FAIL watchdog actual hung expected finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11 reset state
        rdreg(2'd0, 32'd0, "R11 reset address");
        rdreg(2'd2, 32'd0, "R11 reset control");
        rdreg(2'd3, 32'd0, "R11 reset overlay");
        look(8'd0, 24'h0, "R11 reset entry");
        // R7 mode bit readback
        wr(2'd2, 32'hFFFF_FFFF);
        rdreg(2'd2, 32'd1, "R7 control readback");
        // R1 address load
        wr(2'd0, 32'hABCD_0010);
        rdreg(2'd0, 32'h10, "R1 address readback");
        // R3 packed stream
        wr(2'd0, 32'd0);
        wr(2'd1, 32'h1122_3344);
        wr(2'd1, 32'h5566_7788);
        wr(2'd1, 32'h99AA_BBCC);
        look(8'd0, 24'h112233, "R3 entry0");
        look(8'd1, 24'h445566, "R3 entry1");
        look(8'd2, 24'h778899, "R3 entry2");
        look(8'd3, 24'hAABBCC, "R3 entry3");
        rdreg(2'd0, 32'd4, "R3 pointer after packed");
        // R4 / R6 single-byte partial write
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd3);
        wr(2'd1, 32'hDE12_3456);
        look(8'd3, 24'hDEBBCC, "R4 R6 partial entry");
        rdreg(2'd0, 32'd3, "R6 pointer mid entry");
        // R5 reload resets component to red
        wr(2'd0, 32'd3);
        wr(2'd1, 32'h0100_0000);
        look(8'd3, 24'h01BBCC, "R5 red after reload");
        // R2 single-byte order and advance
        wr(2'd0, 32'd5);
        wr(2'd1, 32'hA100_0000);
        wr(2'd1, 32'hA200_0000);
        wr(2'd1, 32'hA300_0000);
        look(8'd5, 24'hA1A2A3, "R2 rgb order");
        rdreg(2'd0, 32'd6, "R2 advance after blue");
        // R8 wrap inside a packed word
        wr(2'd2, 32'd1);
        wr(2'd0, 32'd255);
        wr(2'd1, 32'h0102_0304);
        look(8'd255, 24'h010203, "R8 entry255");
        look(8'd0, 24'h042233, "R8 wrapped entry0");
        rdreg(2'd0, 32'd0, "R8 pointer wrapped");
        // R9 same-cycle write to looked-up entry
        wr(2'd2, 32'd0);
        wr(2'd0, 32'd7);
        @(negedge clk);
        pix_idx = 8'd7;
        wr_en = 1'b1; wr_sel = 2'd1; wr_data = 32'h5A00_0000;
        @(negedge clk);
        wr_en = 1'b0;
        chk(pix_rgb == 24'h0, "R9 old value same cycle", {8'd0, pix_rgb}, 32'h0);
        @(negedge clk);
        chk(pix_rgb == 24'h5A0000, "R9 new value next cycle", {8'd0, pix_rgb}, 32'h5A0000);
        // R10 overlay storage, no side effect on pointers
        wr(2'd3, 32'hCAFE_F00D);
        rdreg(2'd3, 32'hCAFE_F00D, "R10 overlay readback");
        rdreg(2'd0, 32'd7, "R10 pointer untouched");
        wr(2'd1, 32'h6B00_0000);
        look(8'd7, 24'h5A6B00, "R10 component kept");
        // R3 packed starting at blue
        wr(2'd2, 32'd1);
        wr(2'd1, 32'hC1C2_C3C4);
        look(8'd7, 24'h5A6BC1, "R3 blue start");
        look(8'd8, 24'hC2C3C4, "R3 next entry");
        rdreg(2'd0, 32'd9, "R3 pointer after blue start");
        // R12 data register reads zero
        rdreg(2'd1, 32'd0, "R12 data reads zero");
        repeat (2) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule